// File: doc/BRIEF.md
# Pipelined Virtually-Indexed Physically-Tagged Cache Lookup

This block is the read path of a set-associative cache, cut into three pipeline stages so that a fresh lookup may enter on every clock and hits overlap one another. The set is chosen directly from untranslated bits of the virtual address that lie inside the page offset. A translation lookup runs beside it and presents the physical frame number in the same cycle as the request. That frame number is then compared against the physical tag held in every way of the chosen set.

A separate fill port loads a whole line and its physical tag into a way picked by the caller, and marks that way valid. A fill that targets the set of a lookup still in its first or second stage is forwarded into that lookup, so the result never reflects the array as it stood before the fill. Misses are only reported; fetching lines and refilling the translation buffer are handled elsewhere.

Top module: `vipt_lookup_pipe`

## Requirements
- R1: Reset clears every way's valid bit and empties the pipeline: rsp_valid stays 0 until a request has travelled through, and any lookup before a fill reports a miss.
- R2: A request presented with req_valid=1 in cycle n produces exactly one response with rsp_valid=1 in cycle n+2; requests in consecutive cycles yield responses in consecutive cycles, in order, and idle cycles yield rsp_valid=0.
- R3: rsp_hit=1 only when some way of the set has its valid bit set, its stored tag equals tlb_pfn and tlb_hit=1; rsp_data is then word k of that way's line, where k = req_vaddr[3:2] and word k occupies line bits [32k+31:32k] (default parameters).
- R4: When no valid way matches, rsp_miss=1, rsp_hit=0 and rsp_data=0.
- R5: When tlb_hit=0 the response has rsp_miss=1, rsp_tlb_miss=1 and rsp_hit=0 whatever the stored tags hold.
- R6: The set is req_vaddr[7:4] (default parameters); bits at or above the page offset (bit 12 and up) never change which line is selected.
- R7: A fill writes fill_line and fill_pfn into way fill_way of set fill_set and sets its valid bit; the other ways of that set keep their contents, and a way that is refilled no longer matches its old tag.
- R8: A fill issued in the cycle of a lookup's request, or in the following cycle, to the same set is visible in that lookup's response; a fill issued two cycles after the request is not, and is seen by later lookups.
- R9: Elaboration stops with an error unless cache size does not exceed ways times page size, that is unless the index and line-offset bits all lie inside the page offset.
- R10: While rsp_valid=1 exactly one of rsp_hit and rsp_miss is 1, and rsp_tlb_miss=1 only together with rsp_miss; while rsp_valid=0 all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_vaddr | input | VA_W | Virtual byte address of the lookup |
| tlb_pfn | input | PFN_W | Physical frame number from translation, same cycle as the request |
| tlb_hit | input | 1 | Translation succeeded for this request |
| fill_valid | input | 1 | Write a line this cycle |
| fill_set | input | log2(SETS) | Set written by the fill |
| fill_way | input | log2(WAYS) | Way written by the fill |
| fill_pfn | input | PFN_W | Physical tag stored with the line |
| fill_line | input | DATA_W*LINE_WORDS | Whole line of data |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed (tag or translation) |
| rsp_tlb_miss | output | 1 | The miss came from a failed translation |
| rsp_data | output | DATA_W | Addressed word on a hit, zero otherwise |

## Verification
The properties assume that tlb_pfn and tlb_hit belong to the request of the same cycle and that fills never leave two valid ways of one set holding the same tag, since the response only names one way. The stimulus fills each way with a distinct frame number, drives the translation inputs alongside every request, and pairs fills with lookups at offsets of zero, one and two cycles to walk the edges of the forwarding window. The latency properties count cycles since reset, so they make no claim about responses of requests issued before reset was released.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

   // Outcome carried in the last stage of the lookup pipeline.
   typedef enum logic [1:0] {
      RSP_NONE      = 2'd0,
      RSP_HIT       = 2'd1,
      RSP_MISS      = 2'd2,
      RSP_XLAT_MISS = 2'd3
   } rsp_kind_e;

   // Width of an index field that selects one of n items (at least 1 bit).
   function automatic int sel_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   parameter int PFN_W = 20,
   parameter int IDX_W = 4,
   parameter int WAY_W = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [WAYS-1:0][PFN_W-1:0]   rd_tag,
   output logic [WAYS-1:0]              rd_vld,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [WAY_W-1:0]             wr_way,
   input  logic [PFN_W-1:0]             wr_tag
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [PFN_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  vld_q;
      logic             sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q         <= '0;
         else if (sel) vld_q[wr_idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) tag_q[wr_idx] <= wr_tag;
      end

      assign rd_tag[w] = tag_q[rd_idx];
      assign rd_vld[w] = vld_q[rd_idx];
   end

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   parameter int LINE_W = 128,
   parameter int IDX_W  = 4,
   parameter int WAY_W  = 1
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WAY_W-1:0]  rd_way,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [LINE_W-1:0] wr_line
);

   logic [WAYS-1:0][LINE_W-1:0] way_line;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [LINE_W-1:0] mem_q [SETS];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == WAY_W'(w))) mem_q[wr_idx] <= wr_line;
      end

      assign way_line[w] = mem_q[rd_idx];
   end

   if (WAYS == 1) begin : g_single
      assign rd_line = way_line[0];
   end else begin : g_multi
      assign rd_line = way_line[rd_way];
   end

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
   parameter int WAYS  = 2,
   parameter int PFN_W = 20,
   parameter int WAY_W = 1
) (
   input  logic [WAYS-1:0][PFN_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_vld,
   input  logic [PFN_W-1:0]           pfn,
   output logic                       any_hit,
   output logic [WAY_W-1:0]           hit_way
);

   logic [WAYS-1:0] hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_vld[w] && (way_tag[w] == pfn);
   end

   assign any_hit = |hit_vec;

   if (WAYS == 1) begin : g_single
      assign hit_way = '0;
   end else begin : g_enc
      always_comb begin
         hit_way = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/vipt_lookup_pipe.sv
module vipt_lookup_pipe
   import vipt_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PFN_W      = 20,
   parameter int PAGE_BITS  = 12,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 16,
   parameter int WAYS       = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic [VA_W-1:0]                   req_vaddr,
   input  logic [PFN_W-1:0]                  tlb_pfn,
   input  logic                              tlb_hit,
   input  logic                              fill_valid,
   input  logic [sel_bits(SETS)-1:0]         fill_set,
   input  logic [sel_bits(WAYS)-1:0]         fill_way,
   input  logic [PFN_W-1:0]                  fill_pfn,
   input  logic [DATA_W*LINE_WORDS-1:0]      fill_line,
   output logic                              rsp_valid,
   output logic                              rsp_hit,
   output logic                              rsp_miss,
   output logic                              rsp_tlb_miss,
   output logic [DATA_W-1:0]                 rsp_data
);

   localparam int BYTE_OFS    = $clog2(DATA_W / 8);
   localparam int WORD_W      = sel_bits(LINE_WORDS);
   localparam int IDX_W       = sel_bits(SETS);
   localparam int WAY_W       = sel_bits(WAYS);
   localparam int LINE_W      = DATA_W * LINE_WORDS;
   localparam int IDX_LO      = BYTE_OFS + WORD_W;
   localparam int IDX_HI      = IDX_LO + IDX_W;
   localparam longint LINE_BYTES  = longint'(LINE_W / 8);
   localparam longint CACHE_BYTES = longint'(SETS) * longint'(WAYS) * LINE_BYTES;
   localparam longint ALIAS_LIMIT = longint'(WAYS) << PAGE_BITS;

   // ---------------- elaboration-time parameter checks (R9) ----------------
   if (CACHE_BYTES > ALIAS_LIMIT) begin : g_bad_alias_r9
      $error("cache size exceeds ways times page size: index would need translated bits");
   end
   if (IDX_HI > PAGE_BITS) begin : g_bad_index_r9
      $error("set index reaches above the page offset");
   end
   if ((SETS < 2) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if ((LINE_WORDS < 2) || ((LINE_WORDS & (LINE_WORDS - 1)) != 0)) begin : g_bad_words
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if ((WAYS < 1) || ((WAYS & (WAYS - 1)) != 0)) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if ((DATA_W < 16) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_data
      $error("DATA_W must be a power of two, at least 16");
   end
   if (VA_W <= PAGE_BITS) begin : g_bad_va
      $error("VA_W must exceed PAGE_BITS");
   end

   // ---------------- stage 1: select the set, snapshot its tags ----------------
   logic [IDX_W-1:0]             s1_idx;
   logic [WORD_W-1:0]            s1_word;
   logic [WAYS-1:0][PFN_W-1:0]   s1_tag_rd;
   logic [WAYS-1:0]              s1_vld_rd;
   logic [WAYS-1:0][PFN_W-1:0]   s1_tag;
   logic [WAYS-1:0]              s1_vld;
   logic                         unused_va_bits;

   assign s1_idx  = req_vaddr[IDX_LO +: IDX_W];
   assign s1_word = req_vaddr[BYTE_OFS +: WORD_W];
   assign unused_va_bits = ^{req_vaddr[VA_W-1:IDX_HI], req_vaddr[BYTE_OFS-1:0]};

   vipt_tag_store #(
      .SETS (SETS), .WAYS (WAYS), .PFN_W (PFN_W), .IDX_W (IDX_W), .WAY_W (WAY_W)
   ) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (s1_idx),
      .rd_tag (s1_tag_rd),
      .rd_vld (s1_vld_rd),
      .wr_en  (fill_valid),
      .wr_idx (fill_set),
      .wr_way (fill_way),
      .wr_tag (fill_pfn)
   );

   // A fill landing on this set in the same cycle replaces the snapshot of its way.
   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         if (fill_valid && (fill_set == s1_idx) && (fill_way == WAY_W'(w))) begin
            s1_tag[w] = fill_pfn;
            s1_vld[w] = 1'b1;
         end else begin
            s1_tag[w] = s1_tag_rd[w];
            s1_vld[w] = s1_vld_rd[w];
         end
      end
   end

   logic                         s2_valid;
   logic [IDX_W-1:0]             s2_idx;
   logic [WORD_W-1:0]            s2_word;
   logic [PFN_W-1:0]             s2_pfn;
   logic                         s2_xlat_ok;
   logic [WAYS-1:0][PFN_W-1:0]   s2_tag;
   logic [WAYS-1:0]              s2_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid   <= 1'b0;
         s2_idx     <= '0;
         s2_word    <= '0;
         s2_pfn     <= '0;
         s2_xlat_ok <= 1'b0;
         s2_tag     <= '0;
         s2_vld     <= '0;
      end else begin
         s2_valid   <= req_valid;
         s2_idx     <= s1_idx;
         s2_word    <= s1_word;
         s2_pfn     <= tlb_pfn;
         s2_xlat_ok <= tlb_hit;
         s2_tag     <= s1_tag;
         s2_vld     <= s1_vld;
      end
   end

   // ---------------- stage 2: compare tags, read the line ----------------
   logic [WAYS-1:0][PFN_W-1:0]   s2_tag_f;
   logic [WAYS-1:0]              s2_vld_f;
   logic                         s2_any_hit;
   logic [WAY_W-1:0]             s2_hit_way;
   logic [LINE_W-1:0]            s2_line_rd;
   logic [LINE_W-1:0]            s2_line;
   logic                         s2_fill_here;
   rsp_kind_e                    s2_kind;

   assign s2_fill_here = fill_valid && (fill_set == s2_idx);

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         if (s2_fill_here && (fill_way == WAY_W'(w))) begin
            s2_tag_f[w] = fill_pfn;
            s2_vld_f[w] = 1'b1;
         end else begin
            s2_tag_f[w] = s2_tag[w];
            s2_vld_f[w] = s2_vld[w];
         end
      end
   end

   vipt_way_match #(
      .WAYS (WAYS), .PFN_W (PFN_W), .WAY_W (WAY_W)
   ) u_match (
      .way_tag (s2_tag_f),
      .way_vld (s2_vld_f),
      .pfn     (s2_pfn),
      .any_hit (s2_any_hit),
      .hit_way (s2_hit_way)
   );

   vipt_data_store #(
      .SETS (SETS), .WAYS (WAYS), .LINE_W (LINE_W), .IDX_W (IDX_W), .WAY_W (WAY_W)
   ) u_data (
      .clk     (clk),
      .rd_idx  (s2_idx),
      .rd_way  (s2_hit_way),
      .rd_line (s2_line_rd),
      .wr_en   (fill_valid),
      .wr_idx  (fill_set),
      .wr_way  (fill_way),
      .wr_line (fill_line)
   );

   assign s2_line = (s2_fill_here && (fill_way == s2_hit_way)) ? fill_line : s2_line_rd;

   always_comb begin
      if (!s2_valid)        s2_kind = RSP_NONE;
      else if (!s2_xlat_ok) s2_kind = RSP_XLAT_MISS;
      else if (s2_any_hit)  s2_kind = RSP_HIT;
      else                  s2_kind = RSP_MISS;
   end

   rsp_kind_e          s3_kind;
   logic [LINE_W-1:0]  s3_line;
   logic [WORD_W-1:0]  s3_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_kind <= RSP_NONE;
         s3_line <= '0;
         s3_word <= '0;
      end else begin
         s3_kind <= s2_kind;
         s3_line <= (s2_kind == RSP_HIT) ? s2_line : '0;
         s3_word <= s2_word;
      end
   end

   // ---------------- stage 3: pick the word, present the result ----------------
   assign rsp_valid    = (s3_kind != RSP_NONE);
   assign rsp_hit      = (s3_kind == RSP_HIT);
   assign rsp_miss     = (s3_kind == RSP_MISS) || (s3_kind == RSP_XLAT_MISS);
   assign rsp_tlb_miss = (s3_kind == RSP_XLAT_MISS);
   assign rsp_data     = s3_line[s3_word * DATA_W +: DATA_W];

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              tlb_hit,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic              rsp_tlb_miss,
   input logic [DATA_W-1:0] rsp_data
);

   // Cycles since reset release, saturating at 2.
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= 2'd0;
      else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
   end

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd2) |-> !rsp_valid);

   assert_two_cycle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

   assert_miss_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_data == '0));

   assert_xlat_fail_forces_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((age_q == 2'd2) && $past(req_valid, 2) && !$past(tlb_hit, 2))
      |-> (rsp_tlb_miss && rsp_miss && !rsp_hit));

   assert_hit_miss_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

   assert_xlat_flag_with_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_tlb_miss |-> rsp_miss);

   assert_flags_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_tlb_miss));

endmodule

bind vipt_lookup_pipe vipt_lookup_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .tlb_hit      (tlb_hit),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_miss     (rsp_miss),
   .rsp_tlb_miss (rsp_tlb_miss),
   .rsp_data     (rsp_data)
);

// File: tb/sim_vipt_lookup_pipe.sv
module sim_vipt_lookup_pipe;

   localparam int CLK_PERIOD = 10;
   localparam logic [19:0] PFN_BASE = 20'hA5000;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid;
   logic [31:0]  req_vaddr;
   logic [19:0]  tlb_pfn;
   logic         tlb_hit;
   logic         fill_valid;
   logic [3:0]   fill_set;
   logic [0:0]   fill_way;
   logic [19:0]  fill_pfn;
   logic [127:0] fill_line;
   logic         rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss;
   logic [31:0]  rsp_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vipt_lookup_pipe u0 (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_vaddr (req_vaddr),
      .tlb_pfn (tlb_pfn), .tlb_hit (tlb_hit),
      .fill_valid (fill_valid), .fill_set (fill_set), .fill_way (fill_way),
      .fill_pfn (fill_pfn), .fill_line (fill_line),
      .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss),
      .rsp_tlb_miss (rsp_tlb_miss), .rsp_data (rsp_data)
   );

   // Word k of the line held by (set, way): distinct for every place.
   function automatic logic [31:0] pat(input int s, input int w, input int k);
      return {8'(s), 8'(w), 8'(k), 8'hC5};
   endfunction

   function automatic logic [127:0] line_of(input int s, input int w);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[32*k +: 32] = pat(s, w, k);
      return l;
   endfunction

   // Address fields (R3, R6): word at [3:2], set at [7:4], page number from bit 12.
   function automatic logic [31:0] mk_va(input logic [19:0] hi, input int s, input int k);
      return {hi, 4'h0, 4'(s), 2'(k), 2'b00};
   endfunction

   function automatic logic [19:0] pfn_of(input int s, input int w);
      return PFN_BASE + 20'(4 * s + w);
   endfunction

   task automatic check_rsp(input string rq, input logic eh, input logic etm,
                            input logic [31:0] ed);
      n_chk++;
      if (!(rsp_valid === 1'b1 && rsp_hit === eh && rsp_miss === !eh &&
            rsp_tlb_miss === etm && rsp_data === ed)) begin
         n_fail++;
         $display("FAIL %s: got v=%b h=%b m=%b t=%b d=%h, want v=1 h=%b m=%b t=%b d=%h",
                  rq, rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss, rsp_data,
                  eh, !eh, etm, ed);
      end
   endtask

   task automatic check_bit(input string rq, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b, want %b", rq, act, exp);
      end
   endtask

   task automatic do_fill(input int s, input int w, input logic [19:0] p,
                          input logic [127:0] l);
      @(negedge clk);
      fill_valid = 1'b1; fill_set = 4'(s); fill_way = 1'(w);
      fill_pfn = p; fill_line = l;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // One lookup, optionally with a fill fd cycles after the request (fd<0: none).
   task automatic lookup(input string rq, input logic [31:0] va, input logic [19:0] p,
                         input logic th, input int fd, input int fs, input int fw,
                         input logic [19:0] fp, input logic eh, input logic etm,
                         input logic [31:0] ed);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; tlb_pfn = p; tlb_hit = th;
      fill_valid = (fd == 0);
      fill_set = 4'(fs); fill_way = 1'(fw); fill_pfn = fp; fill_line = line_of(fs, fw);
      @(negedge clk);
      req_valid = 1'b0;
      fill_valid = (fd == 1);
      @(negedge clk);
      fill_valid = (fd == 2);
      check_rsp(rq, eh, etm, ed);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [19:0] hi;
      logic [3:0]  set;
      logic [1:0]  word;
      logic [19:0] pfn;
      logic        tlb;
      logic        ehit;
      logic        eway;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{20'h00000, 4'd0, 2'd0, PFN_BASE + 20'd0,  1'b1, 1'b1, 1'b0}, // R3 way 0
      '{20'h00000, 4'd0, 2'd3, PFN_BASE + 20'd1,  1'b1, 1'b1, 1'b1}, // R3 way 1
      '{20'h00005, 4'd1, 2'd2, PFN_BASE + 20'd4,  1'b1, 1'b1, 1'b0}, // R6 high bits
      '{20'h00000, 4'd1, 2'd1, PFN_BASE + 20'd8,  1'b1, 1'b0, 1'b0}, // R4 tag mismatch
      '{20'h00000, 4'd2, 2'd0, PFN_BASE + 20'd9,  1'b0, 1'b0, 1'b0}, // R5 xlat fail
      '{20'h00003, 4'd3, 2'd3, PFN_BASE + 20'd13, 1'b1, 1'b1, 1'b1}, // R3 way 1
      '{20'h00000, 4'd5, 2'd0, PFN_BASE + 20'd20, 1'b1, 1'b0, 1'b0}, // R4 empty set
      '{20'hFFFFF, 4'd3, 2'd0, PFN_BASE + 20'd12, 1'b1, 1'b1, 1'b0}  // R6 top bits
   };

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; tlb_pfn = '0; tlb_hit = 1'b0;
      fill_valid = 1'b0; fill_set = '0; fill_way = '0; fill_pfn = '0; fill_line = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 idle after reset", rsp_valid, 1'b0);

      // R1: before any fill a lookup misses.
      lookup("R1 empty cache", mk_va(20'h0, 0, 0), pfn_of(0, 0), 1'b1, -1, 0, 0, '0,
             1'b0, 1'b0, 32'h0);

      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 2; w++) do_fill(s, w, pfn_of(s, w), line_of(s, w));

      // Table walk: back-to-back requests, each response two cycles later (R2).
      for (int i = 0; i < NV + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            vec_t v;
            v = VECS[i-2];
            check_rsp($sformatf("R2/R3/R4/R5/R6 row %0d", i - 2), v.ehit, !v.tlb,
                      v.ehit ? pat(int'(v.set), int'(v.eway), int'(v.word)) : 32'h0);
         end
         if (i < NV) begin
            req_valid = 1'b1;
            req_vaddr = mk_va(VECS[i].hi, int'(VECS[i].set), int'(VECS[i].word));
            tlb_pfn   = VECS[i].pfn;
            tlb_hit   = VECS[i].tlb;
         end else begin
            req_valid = 1'b0;
         end
      end
      @(negedge clk);
      check_bit("R2 no request gives no response", rsp_valid, 1'b0);

      // R8: fill in the request cycle, and in the next cycle, is forwarded.
      lookup("R8 fill with request", mk_va(20'h0, 6, 1), 20'h33333, 1'b1, 0, 6, 1,
             20'h33333, 1'b1, 1'b0, pat(6, 1, 1));
      lookup("R8 fill one cycle later", mk_va(20'h0, 7, 2), 20'h44444, 1'b1, 1, 7, 0,
             20'h44444, 1'b1, 1'b0, pat(7, 0, 2));
      // R8 boundary: fill two cycles later is too late, then seen afterwards.
      lookup("R8 fill two cycles later", mk_va(20'h0, 8, 3), 20'h55555, 1'b1, 2, 8, 0,
             20'h55555, 1'b0, 1'b0, 32'h0);
      lookup("R8 late fill seen next", mk_va(20'h0, 8, 3), 20'h55555, 1'b1, -1, 0, 0,
             '0, 1'b1, 1'b0, pat(8, 0, 3));

      // R7: filling way 1 leaves way 0 of the set intact.
      do_fill(7, 1, 20'h46666, line_of(7, 1));
      lookup("R7 neighbour way kept", mk_va(20'h0, 7, 0), 20'h44444, 1'b1, -1, 0, 0,
             '0, 1'b1, 1'b0, pat(7, 0, 0));
      lookup("R7 new way hits", mk_va(20'h0, 7, 3), 20'h46666, 1'b1, -1, 0, 0,
             '0, 1'b1, 1'b0, pat(7, 1, 3));

      // R7: refilling a way drops the old tag.
      do_fill(0, 0, 20'h77777, line_of(9, 0));
      lookup("R7 old tag gone", mk_va(20'h0, 0, 1), pfn_of(0, 0), 1'b1, -1, 0, 0,
             '0, 1'b0, 1'b0, 32'h0);
      lookup("R7 new tag hits", mk_va(20'h0, 0, 1), 20'h77777, 1'b1, -1, 0, 0,
             '0, 1'b1, 1'b0, pat(9, 0, 1));

      // R5: a failed translation misses even with a matching tag.
      lookup("R5 xlat fail on match", mk_va(20'h0, 0, 1), 20'h77777, 1'b0, -1, 0, 0,
             '0, 1'b0, 1'b1, 32'h0);

      // R1: a second reset clears every valid bit.
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_bit("R1 idle after second reset", rsp_valid, 1'b0);
      lookup("R1 valid bits cleared", mk_va(20'h0, 0, 1), 20'h77777, 1'b1, -1, 0, 0,
             '0, 1'b0, 1'b0, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got no completion, want completion within 5000 cycles");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule